// File: doc/BRIEF.md
# Banked Gamma Lookup Pixel Stage

This stage corrects the colour of a pixel stream one pixel at a time. Each of the red, green and blue components of a 12-bit-per-component RGB pixel is replaced by an entry from a programmable per-channel table. The entry is chosen by the upper 10 bits of that component. Pixels arrive and leave on valid/ready streams. The pipeline has two register stages and stalls cleanly under backpressure.

Software programs the stage through a simple register write and read port. The table is loaded through a bank-select register and two data windows. In the 10-bit layout one word carries all three channels. In the 12-bit layout red and green share a word in the first window and blue goes in the second window. A difference mode stores each odd entry as an increment over the even entry just below it, and the stage rebuilds the odd value at lookup time. Other controls are a global enable, a relay (bypass) mode, a descending-table option and a frame-size register that software can read back.

Top module: `gamma_lut_stage`

## Requirements
- R1: After reset the enable (0x000), configuration (0x020), size (0x030) and bank (0x100) registers read 0, `out_valid_o` is 0 and `in_ready_o` is 0.
- R2: Reads return the last written value masked to the implemented fields. These are configuration bits 3:0, size bits 28:16 (horizontal) and 12:0 (vertical), and bank bits 2:0. All other bits read 0.
- R3: With configuration bit 0 (relay) set, or configuration bit 1 (table enable) clear, each output pixel equals its input pixel.
- R4: With bank bit 2 clear (10-bit layout), a write to 0x700+4*i loads the entry at index bank*256+i, where the bank is bank bits 1:0. Red comes from data bits 29:20, green from 19:10 and blue from 9:0, and each is stored as value*4 in 12 bits. The lookup index of a component is its bits 11:2.
- R5: With bank bit 2 set (12-bit layout), a write to 0x700+4*i loads red from bits 11:0 and green from bits 23:12. A write to 0xB00+4*i loads blue from bits 11:0. In the 10-bit layout, writes to the 0xB00 window have no effect.
- R6: With configuration bit 3 (difference mode) set, an odd index returns the sum of the stored entry and the entry one below it, saturated at 4095. Even indices return the stored entry.
- R7: With configuration bit 2 (descending) set, the lookup index is 1023 minus the index taken from the component.
- R8: While enable bit 0 is clear, `in_ready_o` and `out_valid_o` are 0 and the pipeline contents are held. Setting the bit again resumes the stream with no pixel lost.
- R9: A pixel accepted with an empty pipeline and `out_ready_i` high appears on the output two clock edges later. Pixels leave in order, with none dropped or duplicated under any `out_ready_i` pattern. The output data stays stable while it is stalled.
- R10: A pixel accepted on the same edge as a table write uses the old entry. The next pixel accepted uses the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted |
| in_rgb_i | input | 36 | Input pixel {R,G,B}, 12 bits each |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_rgb_o | output | 36 | Output pixel {R,G,B}, 12 bits each |

## Verification
The lookup is driven with random pixels over tables that are fully random in each layout. Each layout is run with and without the descending option, so a wrong field slice, bank offset or index mirror shows up as a mismatched channel. Directed pixels pick specific entries. These cover a saturating difference pair, a blue write to the second window while in the 10-bit layout, and a table write on the same edge as a lookup, which separate saturation, ignored writes and write-before-read order. Random downstream readiness, plus an enable drop in the middle of a stream, show whether pixels are lost, repeated or reordered.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam logic [11:0] ADDR_EN   = 12'h000;
  localparam logic [11:0] ADDR_CFG  = 12'h020;
  localparam logic [11:0] ADDR_SIZE = 12'h030;
  localparam logic [11:0] ADDR_BANK = 12'h100;
  localparam logic [11:0] ADDR_WIN0 = 12'h700;
  localparam logic [11:0] ADDR_WIN1 = 12'hB00;
  localparam int          NARROW_W  = 10;

  typedef struct packed {
    logic delta;
    logic desc;
    logic lut_en;
    logic relay;
  } cfg_t;
endpackage

// File: rtl/gamma_regs.sv
module gamma_regs import gamma_pkg::*; #(
  parameter int EW        = 12,
  parameter int IDX_W     = 10,
  parameter int BANK_SIZE = 256
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [11:0]           addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic                  en_o,
  output cfg_t                  cfg_o,
  output logic [2:0]            tab_we_o,
  output logic [IDX_W-1:0]      tab_idx_o,
  output logic [2:0][EW-1:0]    tab_wdata_o
);
  localparam int BSZ_W  = $clog2(BANK_SIZE);
  localparam int BANK_W = IDX_W - BSZ_W;
  localparam logic [11:0] SPAN = 12'(BANK_SIZE * 4);

  logic              en_q;
  cfg_t              cfg_q;
  logic [12:0]       hsize_q, vsize_q;
  logic [BANK_W-1:0] bank_q;
  logic              wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      cfg_q   <= '0;
      hsize_q <= '0;
      vsize_q <= '0;
      bank_q  <= '0;
      wide_q  <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_EN:   en_q  <= wdata_i[0];
        ADDR_CFG:  cfg_q <= cfg_t'(wdata_i[3:0]);
        ADDR_SIZE: begin
          hsize_q <= wdata_i[28:16];
          vsize_q <= wdata_i[12:0];
        end
        ADDR_BANK: begin
          bank_q <= wdata_i[BANK_W-1:0];
          wide_q <= wdata_i[2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_EN:   rdata_o[0]   = en_q;
      ADDR_CFG:  rdata_o[3:0] = cfg_q;
      ADDR_SIZE: begin
        rdata_o[28:16] = hsize_q;
        rdata_o[12:0]  = vsize_q;
      end
      ADDR_BANK: begin
        rdata_o[BANK_W-1:0] = bank_q;
        rdata_o[2]          = wide_q;
      end
      default: ;
    endcase
  end

  // window decode
  logic [11:0] off0, off1;
  logic        hit0, hit1;
  assign off0 = addr_i - ADDR_WIN0;
  assign off1 = addr_i - ADDR_WIN1;
  assign hit0 = we_i && (addr_i >= ADDR_WIN0) && (off0 < SPAN);
  assign hit1 = we_i && (addr_i >= ADDR_WIN1) && (off1 < SPAN);

  always_comb begin
    tab_we_o    = '0;
    tab_wdata_o = '0;
    tab_idx_o   = {bank_q, (hit1 ? off1[BSZ_W+1:2] : off0[BSZ_W+1:2])};
    if (hit0) begin
      if (wide_q) begin
        tab_we_o[2:1]  = 2'b11;
        tab_wdata_o[2] = wdata_i[EW-1:0];
        tab_wdata_o[1] = wdata_i[2*EW-1:EW];
      end else begin
        tab_we_o = 3'b111;
        for (int c = 0; c < 3; c++)
          tab_wdata_o[c] = {wdata_i[c*NARROW_W +: NARROW_W], {(EW-NARROW_W){1'b0}}};
      end
    end else if (hit1 && wide_q) begin
      tab_we_o[0]    = 1'b1;
      tab_wdata_o[0] = wdata_i[EW-1:0];
    end
  end

  assign en_o  = en_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/gamma_lut_mem.sv
module gamma_lut_mem #(
  parameter int EW    = 12,
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [EW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [EW-1:0]    even_o,
  output logic [EW-1:0]    odd_o
);
  localparam int HALF = 2 ** (IDX_W - 1);

  // even/odd split so a difference pair reads in one cycle
  logic [EW-1:0] mem_e [HALF];
  logic [EW-1:0] mem_o [HALF];

  always_ff @(posedge clk_i) begin
    if (we_i && !widx_i[0]) mem_e[widx_i[IDX_W-1:1]] <= wdata_i;
    if (we_i &&  widx_i[0]) mem_o[widx_i[IDX_W-1:1]] <= wdata_i;
  end

  assign even_o = mem_e[ridx_i[IDX_W-1:1]];
  assign odd_o  = mem_o[ridx_i[IDX_W-1:1]];
endmodule

// File: rtl/gamma_pick.sv
module gamma_pick #(
  parameter int EW = 12
) (
  input  logic          pass_i,
  input  logic          delta_i,
  input  logic          odd_i,
  input  logic [EW-1:0] raw_i,
  input  logic [EW-1:0] even_i,
  input  logic [EW-1:0] oddv_i,
  output logic [EW-1:0] val_o
);
  logic [EW:0] sum;
  assign sum = {1'b0, even_i} + {1'b0, oddv_i};

  always_comb begin
    if (pass_i)       val_o = raw_i;
    else if (!odd_i)  val_o = even_i;
    else if (delta_i) val_o = sum[EW] ? {EW{1'b1}} : sum[EW-1:0];
    else              val_o = oddv_i;
  end
endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage import gamma_pkg::*; #(
  parameter int CW        = 12,
  parameter int IDX_W     = 10,
  parameter int BANK_SIZE = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [11:0]     reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [3*CW-1:0] in_rgb_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [3*CW-1:0] out_rgb_o
);
  logic                   en_q;
  cfg_t                   cfg;
  logic [2:0]             tab_we;
  logic [IDX_W-1:0]       tab_idx;
  logic [2:0][CW-1:0]     tab_wdata;

  gamma_regs #(.EW(CW), .IDX_W(IDX_W), .BANK_SIZE(BANK_SIZE)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .en_o(en_q), .cfg_o(cfg),
    .tab_we_o(tab_we), .tab_idx_o(tab_idx), .tab_wdata_o(tab_wdata)
  );

  logic v1_q, v2_q, adv1, adv2;
  logic s1_pass_q, s1_delta_q;
  logic [2:0][CW-1:0] s1_raw_q, s1_even_q, s1_odd_q, rd_even, rd_odd, pick;
  logic [2:0]         s1_lsb_q, rd_lsb;

  assign adv2        = en_q && (!v2_q || out_ready_i);
  assign adv1        = en_q && (!v1_q || adv2);
  assign in_ready_o  = adv1;
  assign out_valid_o = v2_q && en_q;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [IDX_W-1:0] idx;
    assign idx       = cfg.desc ? ~in_rgb_i[c*CW+CW-1 -: IDX_W] : in_rgb_i[c*CW+CW-1 -: IDX_W];
    assign rd_lsb[c] = idx[0];

    gamma_lut_mem #(.EW(CW), .IDX_W(IDX_W)) i_mem (
      .clk_i, .we_i(tab_we[c]), .widx_i(tab_idx), .wdata_i(tab_wdata[c]),
      .ridx_i(idx), .even_o(rd_even[c]), .odd_o(rd_odd[c])
    );

    gamma_pick #(.EW(CW)) i_pick (
      .pass_i(s1_pass_q), .delta_i(s1_delta_q), .odd_i(s1_lsb_q[c]),
      .raw_i(s1_raw_q[c]), .even_i(s1_even_q[c]), .oddv_i(s1_odd_q[c]),
      .val_o(pick[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q       <= 1'b0;
      v2_q       <= 1'b0;
      s1_pass_q  <= 1'b0;
      s1_delta_q <= 1'b0;
      s1_raw_q   <= '0;
      s1_even_q  <= '0;
      s1_odd_q   <= '0;
      s1_lsb_q   <= '0;
      out_rgb_o  <= '0;
    end else begin
      if (adv1) begin
        v1_q       <= in_valid_i;
        s1_pass_q  <= cfg.relay || !cfg.lut_en;
        s1_delta_q <= cfg.delta;
        s1_raw_q   <= in_rgb_i;
        s1_even_q  <= rd_even;
        s1_odd_q   <= rd_odd;
        s1_lsb_q   <= rd_lsb;
      end
      if (adv2) begin
        v2_q <= v1_q;
        if (v1_q) out_rgb_o <= pick;
      end
    end
  end
endmodule

// File: rtl/gamma_lut_stage_chk.sv
module gamma_lut_stage_chk import gamma_pkg::*; #(
  parameter int PW = 36
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [11:0]   reg_addr_i,
  input logic [31:0]   reg_rdata_i,
  input logic          in_ready_i,
  input logic          out_valid_i,
  input logic          out_ready_i,
  input logic [PW-1:0] out_rgb_i
);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |=> $stable(out_rgb_i));

  assert_stall_in_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !in_ready_i);

  assert_stall_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !out_valid_i);

  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(out_rgb_i));

  assert_cfg_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_CFG) |-> (reg_rdata_i[31:4] == '0));

  assert_bank_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_BANK) |-> (reg_rdata_i[31:3] == '0));
endmodule

bind gamma_lut_stage gamma_lut_stage_chk #(.PW(3*CW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q),
  .reg_addr_i(reg_addr_i), .reg_rdata_i(reg_rdata_o),
  .in_ready_i(in_ready_o), .out_valid_i(out_valid_o),
  .out_ready_i(out_ready_i), .out_rgb_i(out_rgb_o)
);

// File: tb/test_gamma_lut_stage.sv
module test_gamma_lut_stage;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [35:0] in_rgb = '0, out_rgb;

  gamma_lut_stage i_gamma_lut_stage (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_rgb_i(in_rgb),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_rgb_o(out_rgb)
  );

  always #2 clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R3";
  logic [11:0] m_tab [3][DEPTH];
  logic  b_relay = 0, b_lut = 0, b_desc = 0, b_delta = 0, b_wide = 0;
  int    b_bank = 0;
  logic [35:0] expq [$];

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [11:0] exp_ch(int ch, logic [11:0] c);
    int idx, s;
    if (b_relay || !b_lut) return c;
    idx = int'(c[11:2]);
    if (b_desc) idx = 1023 - idx;
    if (b_delta && (idx % 2 == 1)) begin
      s = int'(m_tab[ch][idx-1]) + int'(m_tab[ch][idx]);
      if (s > 4095) s = 4095;
      return 12'(s);
    end
    return m_tab[ch][idx];
  endfunction

  function automatic logic [35:0] exp_pix(logic [35:0] p);
    return {exp_ch(2, p[35:24]), exp_ch(1, p[23:12]), exp_ch(0, p[11:0])};
  endfunction

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    int n;
    if (a == 12'h020) {b_delta, b_desc, b_lut, b_relay} = d[3:0];
    if (a == 12'h100) begin b_bank = int'(d[1:0]); b_wide = d[2]; end
    if (a >= 12'h700 && a < 12'hB00) begin
      n = b_bank * 256 + int'((a - 12'h700) >> 2);
      if (b_wide) begin
        m_tab[2][n] = d[11:0];
        m_tab[1][n] = d[23:12];
      end else begin
        m_tab[2][n] = {d[29:20], 2'b00};
        m_tab[1][n] = {d[19:10], 2'b00};
        m_tab[0][n] = {d[9:0], 2'b00};
      end
    end
    if (a >= 12'hB00 && a < 12'hF00 && b_wide) begin
      n = b_bank * 256 + int'((a - 12'hB00) >> 2);
      m_tab[0][n] = d[11:0];
    end
  endtask

  // called just after a falling edge with inputs set; returns at the next falling edge
  task automatic step();
    logic [35:0] e;
    #1;
    if (in_valid && in_ready) expq.push_back(exp_pix(in_rgb));
    if (out_valid && out_ready) begin
      if (expq.size() == 0) check({cur_req, " extra pixel"}, out_rgb, 36'hx);
      else begin e = expq.pop_front(); check(cur_req, out_rgb, e); end
    end
    if (reg_we) model_write(reg_addr, reg_wdata);
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    #1;
    check(req, {4'h0, reg_rdata}, {4'h0, exp});
  endtask

  task automatic drain();
    in_valid = 1'b0; out_ready = 1'b1;
    for (int k = 0; k < 20 && expq.size() != 0; k++) step();
    check({cur_req, " drained"}, 36'(expq.size()), 36'd0);
  endtask

  task automatic stream(int n, int rdy_pct);
    int sent = 0;
    while (sent < n) begin
      in_valid  = ($urandom % 100) < 70;
      in_rgb    = {$urandom, $urandom} & 36'hFFFFFFFFF;
      out_ready = ($urandom % 100) < rdy_pct;
      #1;
      if (in_valid && in_ready) sent++;
      #0 step();
    end
    drain();
  endtask

  task automatic send_one(logic [35:0] p);
    in_valid = 1'b1; in_rgb = p; out_ready = 1'b1;
    step();
    in_valid = 1'b0;
    drain();
  endtask

  task automatic fill();
    for (int b = 0; b < 4; b++) begin
      wr(12'h100, {29'd0, b_wide, 2'(b)});
      for (int i = 0; i < 256; i++) begin
        wr(12'h700 + 12'(i * 4), $urandom);
        if (b_wide) wr(12'hB00 + 12'(i * 4), $urandom);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 36'(out_valid), 36'd0);
    check("R1 in_ready", 36'(in_ready), 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h000, 0, "R1"); rd(12'h020, 0, "R1");
    rd(12'h030, 0, "R1"); rd(12'h100, 0, "R1");

    // R2 readback masks
    wr(12'h020, 32'hFFFF_FFF0);
    rd(12'h020, 32'h0, "R2");
    wr(12'h030, 32'hFFFF_FFFF);
    rd(12'h030, 32'h1FFF_1FFF, "R2");
    wr(12'h030, 32'h0123_0456);
    rd(12'h030, 32'h0123_0456, "R2");
    wr(12'h100, 32'hFFFF_FFFD);
    rd(12'h100, 32'h5, "R2");
    wr(12'h100, 32'h0);
    wr(12'h000, 32'h1);
    rd(12'h000, 32'h1, "R2");

    // R3 pass-through: table off, then relay with table on
    cur_req = "R3"; wr(12'h020, 32'h0); stream(40, 60);
    wr(12'h020, 32'h3); stream(40, 60);

    // R9 latency and order
    cur_req = "R9";
    in_valid = 1'b1; in_rgb = 36'h123456789; out_ready = 1'b1;
    step(); in_valid = 1'b0;
    #1 check("R9 not yet", 36'(out_valid), 36'd0);
    #0 step();
    #1 check("R9 two edges", 36'(out_valid), 36'd1);
    #0 drain();
    stream(150, 35);

    // R4 10-bit layout
    cur_req = "R4"; b_wide = 1'b0; fill();
    wr(12'h020, 32'h2); stream(300, 70);
    cur_req = "R7"; wr(12'h020, 32'h6); stream(150, 70);
    send_one(36'h000_000_000);

    // R10 write and lookup on the same edge
    cur_req = "R10"; wr(12'h020, 32'h2); wr(12'h100, 32'h1);
    out_ready = 1'b1; in_valid = 1'b1; in_rgb = {12'(261 * 4), 12'(261 * 4), 12'(261 * 4)};
    reg_we = 1'b1; reg_addr = 12'h700 + 12'(5 * 4); reg_wdata = 32'h2AB_55_1F3;
    step(); reg_we = 1'b0;
    step(); in_valid = 1'b0; drain();

    // R8 enable dropped mid stream
    cur_req = "R8";
    in_valid = 1'b1; out_ready = 1'b0; in_rgb = 36'hABCDEF012; step();
    in_rgb = 36'h0F0F0F0F0; step(); in_valid = 1'b0;
    wr(12'h000, 32'h0);
    in_valid = 1'b1; out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R8 in_ready", 36'(in_ready), 36'd0);
      check("R8 out_valid", 36'(out_valid), 36'd0);
      #0 step();
    end
    in_valid = 1'b0; wr(12'h000, 32'h1); drain();

    // R5 12-bit layout
    cur_req = "R5"; b_wide = 1'b1; fill();
    stream(300, 70);
    wr(12'h100, 32'h0);
    wr(12'hB00 + 12'(7 * 4), 32'hFFF);
    send_one({12'd0, 12'd0, 12'(7 * 4)});
    wr(12'h100, 32'h4);

    // R6 difference mode with saturation
    cur_req = "R6"; wr(12'h020, 32'hA);
    wr(12'h700, (32'd100 << 12) | 32'd4000); wr(12'hB00, 32'd10);
    wr(12'h704, (32'd50 << 12) | 32'd200);   wr(12'hB04, 32'd4095);
    send_one({12'h005, 12'h005, 12'h005});
    check("R6 sat", 36'(m_tab[2][0]), 36'd4000);
    stream(200, 70);
    cur_req = "R7"; wr(12'h020, 32'hE); stream(150, 50);

    finish_up();
  end
endmodule